// File: doc/BRIEF.md
# Tachometer-Feedback Fan Speed Regulator

This block sets the drive level of a fan from a desired speed. It does not measure speed directly. Instead, a reference pulse train stands for the requested speed and pushes a 6-bit saturating up/down counter upward. Tachometer pulses from the fan, after an optional prescaler, pull the counter downward. The counter settles where the fan's tach rate matches the reference rate. Its value is the 6-bit code for an external fan-voltage DAC.

The reference train starts from a base enable tick of about 8.4 kHz. That tick is divided by a full-scale divisor, which is clamped to 127..255, to give the full-scale rate. The full-scale rate is then thinned by a phase accumulator to setpoint/full-speed-setpoint. The full-speed setpoint depends on a resolution selector.

A mode input bypasses regulation: the setpoint goes straight to the DAC code, the tach input is ignored, and setpoint 64 or above commands full drive. All register values arrive as plain parallel inputs.

Top module: `fan_speed_regulator`

## Requirements
- R1: A synchronous reset makes dacCode 0 and fullDrive 0 on the next clock edge, and clears the base divider, the accumulator, the tach synchronizer and the prescaler.
- R2: A full-scale pulse occurs on every D-th cycle with baseTick high, where D is fullScaleDiv clamped into 127..255 (values below 127 act as 127).
- R3: Each full-scale pulse adds the effective setpoint to a phase accumulator. The full-speed value F is 16 for resSel=0, 32 for resSel=1 and 63 for resSel=2 or 3. A setpoint above F acts as F. A reference pulse is produced whenever the sum reaches F, and F is then subtracted. Over time there are setpoint/F reference pulses per full-scale pulse.
- R4: In closed loop (openLoop=0), each reference pulse raises dacCode by one at the clock edge that ends the cycle of the pulse.
- R5: tachRaw is synchronized by two flip-flops and its rising edges are detected. The prescaler passes every 2^tachDivSel-th edge (1, 2, 4 or 8), and each pulse it passes lowers dacCode by one. A raw rising edge set up before edge k takes effect at edge k+2.
- R6: In closed loop dacCode saturates at 0 and 63. A reference pulse and a tach pulse in the same cycle leave it unchanged.
- R7: With openLoop=1, dacCode follows setpoint[5:0] one clock later for setpoints 0..63, and tach edges have no effect.
- R8: With openLoop=1 and setpoint of 64 or above, dacCode is 63 and fullDrive is 1. fullDrive is 0 in every other case.
- R9: On a switch from open loop to closed loop, dacCode keeps the value it held in open loop, and regulation continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baseTick | input | 1 | Base-rate enable, one cycle wide |
| tachRaw | input | 1 | Raw fan tachometer signal, asynchronous |
| fullScaleDiv | input | 8 | Full-scale divisor, clamped to 127..255 |
| setpoint | input | 7 | Speed setpoint (closed loop) or drive level (open loop) |
| tachDivSel | input | 2 | Tach prescaler select, divide by 2^value |
| resSel | input | 2 | Setpoint resolution: 0 gives 4 bits, 1 gives 5 bits, 2 or 3 gives 6 bits |
| openLoop | input | 1 | 1 selects direct DAC drive, 0 selects regulation |
| dacCode | output | 6 | Fan DAC code |
| fullDrive | output | 1 | Unconditional full drive commanded |

## Verification
Every internal state of this block shows up at dacCode sooner or later. A wrong base divider or accumulator moves the ramp slope, and the error is visible within one full-scale period (127 to 255 base ticks). A prescaler or synchronizer fault shifts a decrement by one or more cycles, which a cycle-by-cycle comparison sees at once. A fault in the saturation or the mode handoff shows as a wrap-around or a jump at the first cycle where the condition holds. The bench therefore compares both outputs on every clock against a behavioural model. It also drives scenarios that make a reference pulse and a tach pulse land on the same edge.

// File: rtl/frs_pkg.sv
package frs_pkg;
  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic inc;       // reference pulse: count up
    logic dec;       // prescaled tach pulse: count down
    logic loadOpen;  // direct-drive mode active
  } frs_strobe_t;
endpackage

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int FS_W   = 8,
  parameter int FS_MIN = 127,
  parameter int CODE_W = 6,
  parameter int TDIV_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baseTick,
  input  logic                tachRaw,
  input  logic [FS_W-1:0]     fullScaleDiv,
  input  logic [CODE_W:0]     setpoint,
  input  logic [TDIV_W-1:0]   tachDivSel,
  input  logic [1:0]          resSel,
  input  logic                openLoop,
  output frs_strobe_t         strb
);
  localparam int SP_W  = CODE_W + 1;
  localparam int ACC_W = CODE_W + 1;
  localparam int PRE_W = (1 << TDIV_W) - 1;

  // full-scale divider
  logic [FS_W-1:0] fsEff, baseCnt;
  logic fsHit;
  assign fsEff = (fullScaleDiv < FS_W'(FS_MIN)) ? FS_W'(FS_MIN) : fullScaleDiv;
  assign fsHit = baseTick && (baseCnt >= fsEff - FS_W'(1));

  always_ff @(posedge clk) begin
    if (rst)           baseCnt <= '0;
    else if (fsHit)    baseCnt <= '0;
    else if (baseTick) baseCnt <= baseCnt + FS_W'(1);
  end

  // phase accumulator scaling the full-scale rate by setpoint/fullSet
  logic [ACC_W-1:0] fullSet, spEff, accReg;
  logic [ACC_W:0]   accSum, accNext;
  logic refHit;

  always_comb begin
    case (resSel)
      2'd0:    fullSet = ACC_W'(1 << (CODE_W - 2));
      2'd1:    fullSet = ACC_W'(1 << (CODE_W - 1));
      default: fullSet = ACC_W'((1 << CODE_W) - 1);
    endcase
  end

  assign spEff   = (setpoint > SP_W'(fullSet)) ? fullSet : ACC_W'(setpoint);
  assign accSum  = {1'b0, accReg} + {1'b0, spEff};
  assign refHit  = fsHit && (accSum >= {1'b0, fullSet});
  assign accNext = refHit ? (accSum - {1'b0, fullSet}) : accSum;

  always_ff @(posedge clk) begin
    if (rst)        accReg <= '0;
    else if (fsHit) accReg <= accNext[ACC_W-1:0];
  end

  // tach synchronizer, edge detect, prescaler
  logic tachS1, tachS2, tachPrev, tachRise, tachHit;
  logic [PRE_W-1:0] preCnt, preLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      tachS1   <= 1'b0;
      tachS2   <= 1'b0;
      tachPrev <= 1'b0;
    end else begin
      tachS1   <= tachRaw;
      tachS2   <= tachS1;
      tachPrev <= tachS2;
    end
  end

  assign tachRise = tachS2 && !tachPrev;
  assign preLast  = ~({PRE_W{1'b1}} << tachDivSel);
  assign tachHit  = tachRise && !openLoop && (preCnt >= preLast);

  always_ff @(posedge clk) begin
    if (rst || openLoop) preCnt <= '0;
    else if (tachRise)   preCnt <= tachHit ? '0 : preCnt + PRE_W'(1);
  end

  assign strb.inc      = refHit;
  assign strb.dec      = tachHit;
  assign strb.loadOpen = openLoop;

  // R2: the divisor is at least 127, so reference pulses are never back to back
  assert_inc_gap_R2: assert property (@(posedge clk) disable iff (rst)
    strb.inc |=> !strb.inc);

  // R5: edge detection never yields two tach pulses in a row
  assert_dec_gap_R5: assert property (@(posedge clk) disable iff (rst)
    strb.dec |=> !strb.dec);
endmodule

// File: rtl/frs_datapath.sv
module frs_datapath
  import frs_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  frs_strobe_t       strb,
  input  logic [CODE_W:0]   setpoint,
  output logic [CODE_W-1:0] dacCode,
  output logic              fullDrive
);
  localparam int SP_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [SP_W-1:0]   SP_FULL  = SP_W'(1 << CODE_W);

  logic spFull;
  assign spFull = (setpoint >= SP_FULL);

  // one register serves as both the counter and the DAC code,
  // so leaving open loop needs no separate preload
  always_ff @(posedge clk) begin
    if (rst) begin
      dacCode   <= '0;
      fullDrive <= 1'b0;
    end else if (strb.loadOpen) begin
      fullDrive <= spFull;
      dacCode   <= spFull ? CODE_MAX : setpoint[CODE_W-1:0];
    end else begin
      fullDrive <= 1'b0;
      if (strb.inc && !strb.dec && dacCode != CODE_MAX)
        dacCode <= dacCode + CODE_W'(1);
      else if (strb.dec && !strb.inc && dacCode != '0)
        dacCode <= dacCode - CODE_W'(1);
    end
  end

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    !strb.loadOpen |=> (dacCode == $past(dacCode)) ||
                       (dacCode == $past(dacCode) + CODE_W'(1)) ||
                       (dacCode == $past(dacCode) - CODE_W'(1)));

  assert_sat_top_R6: assert property (@(posedge clk) disable iff (rst)
    (!strb.loadOpen && dacCode == CODE_MAX && !strb.dec) |=> dacCode == CODE_MAX);

  assert_sat_bot_R6: assert property (@(posedge clk) disable iff (rst)
    (!strb.loadOpen && dacCode == '0 && !strb.inc) |=> dacCode == '0);

  assert_full_R8: assert property (@(posedge clk) disable iff (rst)
    fullDrive |-> dacCode == CODE_MAX);
endmodule

// File: rtl/fan_speed_regulator.sv
module fan_speed_regulator
  import frs_pkg::*;
#(
  parameter int FS_W   = 8,
  parameter int FS_MIN = 127,
  parameter int CODE_W = 6,
  parameter int TDIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baseTick,
  input  logic              tachRaw,
  input  logic [FS_W-1:0]   fullScaleDiv,
  input  logic [CODE_W:0]   setpoint,
  input  logic [TDIV_W-1:0] tachDivSel,
  input  logic [1:0]        resSel,
  input  logic              openLoop,
  output logic [CODE_W-1:0] dacCode,
  output logic              fullDrive
);
  frs_strobe_t strb;

  frs_ctrl #(
    .FS_W(FS_W), .FS_MIN(FS_MIN), .CODE_W(CODE_W), .TDIV_W(TDIV_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .baseTick(baseTick), .tachRaw(tachRaw),
    .fullScaleDiv(fullScaleDiv), .setpoint(setpoint), .tachDivSel(tachDivSel),
    .resSel(resSel), .openLoop(openLoop), .strb(strb)
  );

  frs_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .setpoint(setpoint),
    .dacCode(dacCode), .fullDrive(fullDrive)
  );
endmodule

// File: tb/fan_speed_regulator_test.sv
module fan_speed_regulator_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baseTick = 1'b0;
  logic       tachRaw = 1'b0;
  logic [7:0] fullScaleDiv = 8'd127;
  logic [6:0] setpoint = 7'd0;
  logic [1:0] tachDivSel = 2'd0;
  logic [1:0] resSel = 2'd2;
  logic       openLoop = 1'b0;
  logic [5:0] dacCode;
  logic       fullDrive;

  int total = 0;
  int bad = 0;
  string phase = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  fan_speed_regulator uut (
    .clk(clk), .rst(rst), .baseTick(baseTick), .tachRaw(tachRaw),
    .fullScaleDiv(fullScaleDiv), .setpoint(setpoint), .tachDivSel(tachDivSel),
    .resSel(resSel), .openLoop(openLoop), .dacCode(dacCode), .fullDrive(fullDrive)
  );

  // behavioural reference model, advanced on every rising edge
  int mBase = 0, mAcc = 0, mPre = 0, mDac = 0;
  int mS1 = 0, mS2 = 0, mPrev = 0;
  bit mFull = 0;

  always @(posedge clk) begin
    if (rst) begin
      mBase = 0; mAcc = 0; mPre = 0; mDac = 0;
      mS1 = 0; mS2 = 0; mPrev = 0; mFull = 0;
    end else begin
      int d, f, sp, divisor;
      bit fs, up, down, rise;
      d  = (fullScaleDiv < 127) ? 127 : int'(fullScaleDiv);
      fs = baseTick && (mBase >= d - 1);
      f  = (resSel == 0) ? 16 : (resSel == 1) ? 32 : 63;
      sp = (int'(setpoint) > f) ? f : int'(setpoint);
      up = 0;
      if (fs) begin
        mAcc = mAcc + sp;
        if (mAcc >= f) begin up = 1; mAcc = mAcc - f; end
      end
      if (fs) mBase = 0; else if (baseTick) mBase = mBase + 1;
      rise = (mS2 == 1) && (mPrev == 0);
      mPrev = mS2; mS2 = mS1; mS1 = int'(tachRaw);
      divisor = 1 << tachDivSel;
      down = 0;
      if (openLoop) mPre = 0;
      else if (rise) begin
        if (mPre >= divisor - 1) begin down = 1; mPre = 0; end
        else mPre = mPre + 1;
      end
      if (openLoop) begin
        mFull = (setpoint >= 64);
        mDac  = mFull ? 63 : int'(setpoint);
      end else begin
        mFull = 0;
        if (up && !down && mDac < 63) mDac = mDac + 1;
        else if (down && !up && mDac > 0) mDac = mDac - 1;
      end
    end
  end

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      total++;
      if (int'(dacCode) != mDac || fullDrive != mFull) begin
        bad++;
        $display("FAIL %s model: dacCode=%0d fullDrive=%0d expected %0d/%0d at %0t",
                 phase, dacCode, fullDrive, mDac, mFull, $time);
      end
    end
  end

  task automatic checkCode(input int expCode, input bit expFull, input string tag);
    total++;
    if (int'(dacCode) != expCode || fullDrive != expFull) begin
      bad++;
      $display("FAIL %s: dacCode=%0d fullDrive=%0d expected %0d/%0d",
               tag, dacCode, fullDrive, expCode, expFull);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    cycles(3);
    rst = 1'b0;
  endtask

  task automatic tachPulses(input int n);
    for (int i = 0; i < n; i++) begin
      tachRaw = 1'b1; cycles(3);
      tachRaw = 1'b0; cycles(3);
    end
  endtask

  initial begin
    // R1 reset state
    cycles(4);
    checkCode(0, 0, "R1 reset");
    rst = 1'b0;

    // R4 ramp: full setpoint, one increment per 127 ticks
    phase = "R4"; baseTick = 1'b1; setpoint = 7'd63; resSel = 2'd2;
    cycles(127 * 10 + 5);
    checkCode(10, 0, "R4 ramp after 10 full-scale periods");

    // R2 clamp from below
    phase = "R2"; baseTick = 1'b0; fullScaleDiv = 8'd20; doReset();
    baseTick = 1'b1;
    cycles(127 * 10 + 5);
    checkCode(10, 0, "R2 divisor 20 clamped to 127");
    baseTick = 1'b0; fullScaleDiv = 8'd255; doReset();
    baseTick = 1'b1;
    cycles(255 * 4 + 5);
    checkCode(4, 0, "R2 divisor 255");

    // R3 scaling at 4-bit resolution
    phase = "R3"; baseTick = 1'b0; fullScaleDiv = 8'd127; resSel = 2'd0;
    setpoint = 7'd8; doReset();
    baseTick = 1'b1;
    cycles(127 * 20 + 5);
    checkCode(10, 0, "R3 half speed, one step per two periods");
    baseTick = 1'b0; setpoint = 7'd100; doReset();
    baseTick = 1'b1;
    cycles(127 * 5 + 5);
    checkCode(5, 0, "R3 setpoint above 16 acts as full");

    // R6 top saturation
    phase = "R6"; baseTick = 1'b0; resSel = 2'd2; setpoint = 7'd63; doReset();
    baseTick = 1'b1;
    cycles(127 * 70);
    checkCode(63, 0, "R6 saturate at 63");

    // R5 prescaler
    phase = "R5"; setpoint = 7'd0; tachDivSel = 2'd3;
    tachPulses(16); cycles(5);
    checkCode(61, 0, "R5 divide by 8, 16 edges");
    tachDivSel = 2'd0;
    tachPulses(10); cycles(5);
    checkCode(51, 0, "R5 divide by 1, 10 edges");
    phase = "R6";
    tachPulses(60); cycles(5);
    checkCode(0, 0, "R6 saturate at 0");

    // R7 open loop, tach ignored
    phase = "R7"; openLoop = 1'b1; setpoint = 7'd40;
    cycles(2);
    checkCode(40, 0, "R7 direct drive 40");
    tachPulses(20); cycles(3);
    checkCode(40, 0, "R7 tach ignored");

    // R8 full drive
    phase = "R8"; setpoint = 7'd64; cycles(2);
    checkCode(63, 1, "R8 setpoint 64");
    setpoint = 7'd100; cycles(2);
    checkCode(63, 1, "R8 setpoint 100");
    setpoint = 7'd63; cycles(2);
    checkCode(63, 0, "R8 setpoint 63 not full");

    // R9 handoff keeps code; base divider cleared by reset first
    phase = "R9"; baseTick = 1'b0; openLoop = 1'b0; doReset();
    openLoop = 1'b1; setpoint = 7'd40; cycles(3);
    openLoop = 1'b0; setpoint = 7'd63; resSel = 2'd2; tachDivSel = 2'd0;
    cycles(5);
    checkCode(40, 0, "R9 code held after leaving open loop");

    // R6 coincident up and down
    phase = "R6";
    for (int i = 0; i < 126; i++) begin
      baseTick = 1'b1; cycles(1);
      baseTick = 1'b0; cycles(1);
    end
    checkCode(40, 0, "R6 no step before 127th tick");
    tachRaw = 1'b1; cycles(2);
    baseTick = 1'b1; cycles(1);
    baseTick = 1'b0; cycles(3);
    checkCode(40, 0, "R6 simultaneous up and down");
    tachRaw = 1'b0; cycles(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule